// File: doc/BRIEF.md
# Calendar Counter Chain

This block keeps wall-clock time and calendar date from a single one-second strobe. Seconds, minutes and hours count from zero. The day of the month, the month and the day of the week count from one. The year is a two-digit counter. A tick that completes a minute, hour, day, month or year carries through every affected field in the same clock cycle. The length of the current month is derived from the month and from a leap test on the year, and it is brought out so that a setting controller can use it as its wrap limit.

Every field can be overwritten by an external setting controller. Each field has its own active-low load strobe and preset bus. A loaded field takes the preset instead of counting, and it passes no carry upward in that cycle. When a month or year load leaves the day of the month beyond the new month length, the day is pulled down to that length. Display, digit splitting, key handling and clock division are left to neighbouring blocks.

Top module: `calendar_core`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets seconds, minutes, hours and year to 0 and day, month and weekday to 1. Reset takes priority over every load strobe.
- R2: Each clock edge with tick high advances seconds by one. Seconds and minutes count 0 to 59 and hours count 0 to 23, each wrapping to 0. Without tick and without loads, every field holds its value.
- R3: Carries ripple within one tick. Seconds at 59 advance minutes, minutes at 59 advance hours, and hours at 23 advance the day of month and the weekday together. The last day of a month advances the month, and month 12 advances the year. From day 31, month 12, year 99, 23:59:59 with weekday 7, one tick gives 00:00:00 on day 1, month 1, year 0, weekday 1.
- R4: month_days is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11.
- R5: For month 2, month_days is 29 when the year is divisible by LEAP_PERIOD (default 4, so year 0 is a leap year) and 28 otherwise.
- R6: The day of month counts from 1 up to month_days and then returns to 1 while advancing the month. The month counts 1 to 12 and returns to 1. The year counts 0 to YEAR_SPAN-1 (default 99) and returns to 0.
- R7: The weekday counts 1 to WEEK_LEN (default 7), returns to 1, and advances in the same cycle as the day of month.
- R8: While a field's load strobe is low at a clock edge, that field takes its preset value regardless of tick. A loaded field produces no carry into the next field in that cycle.
- R9: When the day of month exceeds month_days and the day is neither loaded nor advanced, the day becomes month_days at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| sec_ld_n | input | 1 | Seconds load strobe, active low |
| sec_set | input | 6 | Seconds preset |
| min_ld_n | input | 1 | Minutes load strobe, active low |
| min_set | input | 6 | Minutes preset |
| hr_ld_n | input | 1 | Hours load strobe, active low |
| hr_set | input | 5 | Hours preset |
| day_ld_n | input | 1 | Day-of-month load strobe, active low |
| day_set | input | 5 | Day-of-month preset |
| mon_ld_n | input | 1 | Month load strobe, active low |
| mon_set | input | 4 | Month preset |
| yr_ld_n | input | 1 | Year load strobe, active low |
| yr_set | input | YR_W (7) | Year preset |
| wd_ld_n | input | 1 | Weekday load strobe, active low |
| wd_set | input | WD_W (3) | Weekday preset |
| sec_q | output | 6 | Current seconds |
| min_q | output | 6 | Current minutes |
| hr_q | output | 5 | Current hours |
| day_q | output | 5 | Current day of month |
| mon_q | output | 4 | Current month |
| yr_q | output | YR_W (7) | Current year |
| wd_q | output | WD_W (3) | Current weekday |
| month_days | output | 5 | Number of days in the current month and year |

## Verification
The range assertions assume that every preset lies inside its field's legal range: 0 to 59 for seconds and minutes, 0 to 23 for hours, 1 to 31 for the day, 1 to 12 for the month, 0 to 99 for the year and 1 to 7 for the weekday. The bench loads only values inside these ranges. The clamp check is the one place where the day may briefly sit above month_days. That happens only for the single cycle after a month or year load, and the stimulus creates exactly that case on purpose. Ticks are one cycle wide and never coincide with reset, except in the case that checks reset priority.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int SEC_W     = 6;
   localparam int HR_W      = 5;
   localparam int DAY_W     = 5;
   localparam int MON_W     = 4;
   localparam int SEC_TOP   = 59;
   localparam int HR_TOP    = 23;
   localparam int MON_TOP   = 12;
   localparam int DAYS_LONG = 31;
   localparam int DAYS_MID  = 30;
   localparam int DAYS_FEB  = 28;
endpackage

// File: rtl/cal_wrap_ctr.sv
module cal_wrap_ctr #(
   parameter int W  = 6,
   parameter int LO = 0,
   parameter int HI = 59
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         ld_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         carry
);
   localparam logic [W-1:0] LO_V = W'(LO);
   localparam logic [W-1:0] HI_V = W'(HI);

   generate
      if (HI <= LO || HI >= (1 << W)) begin : g_bad_cfg
         $error("cal_wrap_ctr: range does not fit the width");
      end
   endgenerate

   assign carry = inc & ld_n & (q == HI_V);

   always_ff @(posedge clk) begin
      if (rst)            q <= LO_V;
      else if (!ld_n)     q <= d;
      else if (inc)       q <= (q == HI_V) ? LO_V : q + W'(1);
   end

   // R8
   load_take_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_n |=> q == $past(d));
   // R2
   wrap_to_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && ld_n && q == HI_V) |=> q == LO_V);
   // R2
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && ld_n && q != HI_V) |=> q == $past(q) + W'(1));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_n && !inc) |=> $stable(q));
   // R6
   in_range_chk: assert property (@(posedge clk) disable iff (rst)
      q >= LO_V && q <= HI_V);
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
   parameter int MW          = 4,
   parameter int YW          = 7,
   parameter int DW          = 5,
   parameter int LEAP_PERIOD = 4
) (
   input  logic [MW-1:0] mon,
   input  logic [YW-1:0] yr,
   output logic [DW-1:0] days
);
   import cal_pkg::*;

   localparam bool_pow2 = ((LEAP_PERIOD & (LEAP_PERIOD - 1)) == 0);
   logic leap;

   generate
      if (LEAP_PERIOD < 1) begin : g_bad_period
         $error("cal_month_len: leap period must be positive");
      end
      if (bool_pow2) begin : g_mask_leap
         assign leap = (yr & YW'(LEAP_PERIOD - 1)) == '0;
      end else begin : g_mod_leap
         assign leap = (yr % YW'(LEAP_PERIOD)) == '0;
      end
   endgenerate

   always_comb begin
      case (mon)
         MW'(2):                    days = leap ? DW'(DAYS_FEB + 1) : DW'(DAYS_FEB);
         MW'(4), MW'(6),
         MW'(9), MW'(11):           days = DW'(DAYS_MID);
         default:                   days = DW'(DAYS_LONG);
      endcase
   end
endmodule

// File: rtl/cal_day_ctr.sv
module cal_day_ctr #(
   parameter int DW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          ld_n,
   input  logic [DW-1:0] d,
   input  logic [DW-1:0] limit,
   output logic [DW-1:0] q,
   output logic          carry
);
   import cal_pkg::*;
   localparam logic [DW-1:0] ONE    = DW'(1);
   localparam logic [DW-1:0] TOP_V  = DW'(DAYS_LONG);

   generate
      if (DAYS_LONG >= (1 << DW)) begin : g_bad_width
         $error("cal_day_ctr: day width too small");
      end
   endgenerate

   assign carry = inc & ld_n & (q >= limit);

   always_ff @(posedge clk) begin
      if (rst)              q <= ONE;
      else if (!ld_n)       q <= d;
      else if (inc)         q <= (q >= limit) ? ONE : q + ONE;
      else if (q > limit)   q <= limit;
   end

   // R9
   clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_n && !inc && q > limit) |=> q == $past(limit));
   // R6
   day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && ld_n && q >= limit) |=> q == ONE);
   // R8
   day_load_chk: assert property (@(posedge clk) disable iff (rst)
      !ld_n |=> q == $past(d));
   // R6
   day_range_chk: assert property (@(posedge clk) disable iff (rst)
      q >= ONE && q <= TOP_V);
endmodule

// File: rtl/calendar_core.sv
module calendar_core #(
   parameter int YEAR_SPAN   = 100,
   parameter int WEEK_LEN    = 7,
   parameter int LEAP_PERIOD = 4,
   localparam int YR_W       = $clog2(YEAR_SPAN),
   localparam int WD_W       = $clog2(WEEK_LEN + 1)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      tick,
   input  logic                      sec_ld_n,
   input  logic [cal_pkg::SEC_W-1:0] sec_set,
   input  logic                      min_ld_n,
   input  logic [cal_pkg::SEC_W-1:0] min_set,
   input  logic                      hr_ld_n,
   input  logic [cal_pkg::HR_W-1:0]  hr_set,
   input  logic                      day_ld_n,
   input  logic [cal_pkg::DAY_W-1:0] day_set,
   input  logic                      mon_ld_n,
   input  logic [cal_pkg::MON_W-1:0] mon_set,
   input  logic                      yr_ld_n,
   input  logic [YR_W-1:0]           yr_set,
   input  logic                      wd_ld_n,
   input  logic [WD_W-1:0]           wd_set,
   output logic [cal_pkg::SEC_W-1:0] sec_q,
   output logic [cal_pkg::SEC_W-1:0] min_q,
   output logic [cal_pkg::HR_W-1:0]  hr_q,
   output logic [cal_pkg::DAY_W-1:0] day_q,
   output logic [cal_pkg::MON_W-1:0] mon_q,
   output logic [YR_W-1:0]           yr_q,
   output logic [WD_W-1:0]           wd_q,
   output logic [cal_pkg::DAY_W-1:0] month_days
);
   import cal_pkg::*;

   generate
      if (YEAR_SPAN < 2) begin : g_bad_span
         $error("calendar_core: year span too small");
      end
      if (WEEK_LEN < 2) begin : g_bad_week
         $error("calendar_core: week length too small");
      end
   endgenerate

   logic sec_c, min_c, hr_c, day_c, mon_c, yr_wrap, wd_wrap;

   cal_wrap_ctr #(.W(SEC_W), .LO(0), .HI(SEC_TOP)) u_sec (
      .clk(clk), .rst(rst), .inc(tick), .ld_n(sec_ld_n), .d(sec_set),
      .q(sec_q), .carry(sec_c));

   cal_wrap_ctr #(.W(SEC_W), .LO(0), .HI(SEC_TOP)) u_min (
      .clk(clk), .rst(rst), .inc(sec_c), .ld_n(min_ld_n), .d(min_set),
      .q(min_q), .carry(min_c));

   cal_wrap_ctr #(.W(HR_W), .LO(0), .HI(HR_TOP)) u_hr (
      .clk(clk), .rst(rst), .inc(min_c), .ld_n(hr_ld_n), .d(hr_set),
      .q(hr_q), .carry(hr_c));

   cal_month_len #(.MW(MON_W), .YW(YR_W), .DW(DAY_W),
                   .LEAP_PERIOD(LEAP_PERIOD)) u_len (
      .mon(mon_q), .yr(yr_q), .days(month_days));

   cal_day_ctr #(.DW(DAY_W)) u_day (
      .clk(clk), .rst(rst), .inc(hr_c), .ld_n(day_ld_n), .d(day_set),
      .limit(month_days), .q(day_q), .carry(day_c));

   cal_wrap_ctr #(.W(WD_W), .LO(1), .HI(WEEK_LEN)) u_wd (
      .clk(clk), .rst(rst), .inc(hr_c), .ld_n(wd_ld_n), .d(wd_set),
      .q(wd_q), .carry(wd_wrap));

   cal_wrap_ctr #(.W(MON_W), .LO(1), .HI(MON_TOP)) u_mon (
      .clk(clk), .rst(rst), .inc(day_c), .ld_n(mon_ld_n), .d(mon_set),
      .q(mon_q), .carry(mon_c));

   cal_wrap_ctr #(.W(YR_W), .LO(0), .HI(YEAR_SPAN - 1)) u_yr (
      .clk(clk), .rst(rst), .inc(mon_c), .ld_n(yr_ld_n), .d(yr_set),
      .q(yr_q), .carry(yr_wrap));

   // R3
   min_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && sec_ld_n && min_ld_n && sec_q == SEC_W'(SEC_TOP) &&
       min_q != SEC_W'(SEC_TOP)) |=> min_q == $past(min_q) + SEC_W'(1));
   // R7
   wd_with_day_chk: assert property (@(posedge clk) disable iff (rst)
      (hr_c && wd_ld_n && wd_q != WD_W'(WEEK_LEN)) |=> wd_q == $past(wd_q) + WD_W'(1));
   // R7
   wd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      wd_wrap |=> wd_q == WD_W'(1));
   // R6
   yr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      yr_wrap |=> yr_q == '0);
   // R5
   feb_leap_chk: assert property (@(posedge clk) disable iff (rst)
      (mon_q == MON_W'(2) && (yr_q % YR_W'(LEAP_PERIOD)) == '0) |-> month_days == DAY_W'(DAYS_FEB + 1));
   // R4
   len_range_chk: assert property (@(posedge clk) disable iff (rst)
      month_days >= DAY_W'(DAYS_FEB) && month_days <= DAY_W'(DAYS_LONG));
   // R1
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (sec_q == '0 && day_q == DAY_W'(1) && mon_q == MON_W'(1) && wd_q == WD_W'(1)));
endmodule

// File: tb/calendar_core_tb_top.sv
module calendar_core_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic sec_ld_n = 1'b1, min_ld_n = 1'b1, hr_ld_n = 1'b1, day_ld_n = 1'b1;
   logic mon_ld_n = 1'b1, yr_ld_n = 1'b1, wd_ld_n = 1'b1;
   logic [5:0] sec_set = '0, min_set = '0;
   logic [4:0] hr_set = '0, day_set = 5'd1;
   logic [3:0] mon_set = 4'd1;
   logic [6:0] yr_set = '0;
   logic [2:0] wd_set = 3'd1;
   logic [5:0] sec_q, min_q;
   logic [4:0] hr_q, day_q, month_days;
   logic [3:0] mon_q;
   logic [6:0] yr_q;
   logic [2:0] wd_q;

   always #5 clk = ~clk;

   calendar_core dut_i (
      .clk(clk), .rst(rst), .tick(tick),
      .sec_ld_n(sec_ld_n), .sec_set(sec_set), .min_ld_n(min_ld_n), .min_set(min_set),
      .hr_ld_n(hr_ld_n), .hr_set(hr_set), .day_ld_n(day_ld_n), .day_set(day_set),
      .mon_ld_n(mon_ld_n), .mon_set(mon_set), .yr_ld_n(yr_ld_n), .yr_set(yr_set),
      .wd_ld_n(wd_ld_n), .wd_set(wd_set),
      .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .day_q(day_q), .mon_q(mon_q),
      .yr_q(yr_q), .wd_q(wd_q), .month_days(month_days));

   typedef struct {
      string tag;
      int s, mi, h, d, mo, y, w, md;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model state and presets
   int m_s = 0, m_mi = 0, m_h = 0, m_d = 1, m_mo = 1, m_y = 0, m_w = 1;
   int p_s = 0, p_mi = 0, p_h = 0, p_d = 1, p_mo = 1, p_y = 0, p_w = 1;

   function automatic int mdays(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   // load mask bits: 0 sec, 1 min, 2 hr, 3 day, 4 mon, 5 yr, 6 weekday
   task automatic step(input string tag, input bit t, input bit r, input logic [6:0] lm);
      int lim, n_s, n_mi, n_h, n_d, n_mo, n_y, n_w;
      bit i_m, i_h, i_d, i_mo, i_y;
      exp_t e;
      @(negedge clk);
      tick = t; rst = r;
      sec_ld_n = ~lm[0]; min_ld_n = ~lm[1]; hr_ld_n = ~lm[2]; day_ld_n = ~lm[3];
      mon_ld_n = ~lm[4]; yr_ld_n = ~lm[5]; wd_ld_n = ~lm[6];
      sec_set = 6'(p_s); min_set = 6'(p_mi); hr_set = 5'(p_h); day_set = 5'(p_d);
      mon_set = 4'(p_mo); yr_set = 7'(p_y); wd_set = 3'(p_w);
      lim  = mdays(m_mo, m_y);
      i_m  = t && !lm[0] && m_s == 59;
      i_h  = i_m && !lm[1] && m_mi == 59;
      i_d  = i_h && !lm[2] && m_h == 23;
      i_mo = i_d && !lm[3] && m_d >= lim;
      i_y  = i_mo && !lm[4] && m_mo == 12;
      if (r) begin
         n_s = 0; n_mi = 0; n_h = 0; n_d = 1; n_mo = 1; n_y = 0; n_w = 1;
      end else begin
         n_s  = lm[0] ? p_s  : t    ? (m_s == 59 ? 0 : m_s + 1)   : m_s;
         n_mi = lm[1] ? p_mi : i_m  ? (m_mi == 59 ? 0 : m_mi + 1) : m_mi;
         n_h  = lm[2] ? p_h  : i_h  ? (m_h == 23 ? 0 : m_h + 1)   : m_h;
         n_d  = lm[3] ? p_d  : i_d  ? (m_d >= lim ? 1 : m_d + 1)  : (m_d > lim ? lim : m_d);
         n_mo = lm[4] ? p_mo : i_mo ? (m_mo == 12 ? 1 : m_mo + 1) : m_mo;
         n_y  = lm[5] ? p_y  : i_y  ? (m_y == 99 ? 0 : m_y + 1)   : m_y;
         n_w  = lm[6] ? p_w  : i_d  ? (m_w == 7 ? 1 : m_w + 1)    : m_w;
      end
      m_s = n_s; m_mi = n_mi; m_h = n_h; m_d = n_d; m_mo = n_mo; m_y = n_y; m_w = n_w;
      e.tag = tag; e.s = n_s; e.mi = n_mi; e.h = n_h; e.d = n_d; e.mo = n_mo;
      e.y = n_y; e.w = n_w; e.md = mdays(n_mo, n_y);
      exp_q.push_back(e);
   endtask

   // monitor: compares after each edge, once the registers settle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (int'(sec_q) != e.s || int'(min_q) != e.mi || int'(hr_q) != e.h ||
                int'(day_q) != e.d || int'(mon_q) != e.mo || int'(yr_q) != e.y ||
                int'(wd_q) != e.w || int'(month_days) != e.md) begin
               fails++;
               $display("FAIL %s: actual %0d:%0d:%0d d%0d m%0d y%0d w%0d len%0d expected %0d:%0d:%0d d%0d m%0d y%0d w%0d len%0d",
                  e.tag, hr_q, min_q, sec_q, day_q, mon_q, yr_q, wd_q, month_days,
                  e.h, e.mi, e.s, e.d, e.mo, e.y, e.w, e.md);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual no finish expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      step("R1", 0, 1, 7'h00);
      step("R1", 0, 1, 7'h00);
      // R2: hold without tick
      repeat (3) step("R2", 0, 0, 7'h00);
      // R2: seconds count and wrap, minutes follow
      repeat (65) step("R2", 1, 0, 7'h00);
      // R3: hour rollover into day and weekday
      p_s = 59; p_mi = 59; p_h = 23;
      step("R8", 0, 0, 7'h07);
      step("R3", 1, 0, 7'h00);
      // R4: month lengths in a leap year 0
      for (int m = 1; m <= 12; m++) begin
         p_mo = m;
         step("R4", 0, 0, 7'h10);
      end
      // R5: February against the leap test
      p_mo = 2; p_y = 1;  step("R5", 0, 0, 7'h30);
      p_y = 4;            step("R5", 0, 0, 7'h20);
      p_y = 0;            step("R5", 0, 0, 7'h20);
      p_y = 99;           step("R5", 0, 0, 7'h20);
      // R6: Feb 28 in a common year goes to March 1
      p_s = 59; p_mi = 59; p_h = 23; p_d = 28; p_mo = 2; p_y = 1;
      step("R6", 0, 0, 7'h3F);
      step("R6", 1, 0, 7'h00);
      // R5: Feb 28 in a leap year goes to Feb 29
      p_y = 8;
      step("R5", 0, 0, 7'h3F);
      step("R5", 1, 0, 7'h00);
      // R3 / R7: full cascade at year end with weekday 7
      p_d = 31; p_mo = 12; p_y = 99; p_w = 7;
      step("R3", 0, 0, 7'h7F);
      step("R3", 1, 0, 7'h00);
      // R7: weekday mid-week advance
      p_w = 3; p_d = 10; p_mo = 5;
      step("R7", 0, 0, 7'h7F);
      step("R7", 1, 0, 7'h00);
      // R8: seconds load overrides tick and passes no carry
      p_s = 59; p_mi = 10;
      step("R8", 0, 0, 7'h03);
      step("R8", 1, 0, 7'h01);
      step("R8", 1, 0, 7'h00);
      // R9: month load below current day clamps next cycle
      p_d = 31; p_mo = 1; p_y = 5;
      step("R9", 0, 0, 7'h38);
      p_mo = 2;
      step("R9", 0, 0, 7'h10);
      step("R9", 0, 0, 7'h00);
      step("R9", 0, 0, 7'h00);
      // R9: year load leaves Feb 29 in a common year
      p_d = 29; p_mo = 2; p_y = 4;
      step("R9", 0, 0, 7'h38);
      p_y = 5;
      step("R9", 0, 0, 7'h20);
      step("R9", 0, 0, 7'h00);
      // R9: 31 into a 30-day month
      p_d = 31; p_mo = 3;
      step("R9", 0, 0, 7'h18);
      p_mo = 4;
      step("R9", 0, 0, 7'h10);
      step("R9", 0, 0, 7'h00);
      // R1: reset wins over loads and tick
      p_s = 30; p_d = 15; p_mo = 7; p_w = 4;
      step("R1", 1, 1, 7'h7F);
      step("R1", 0, 0, 7'h00);
      @(negedge clk);
      rst = 1'b0; tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule